// File: doc/BRIEF.md
# Genlocked Horizontal Line Timer

This block produces the horizontal timing of a video encoder, one step per pixel clock. It keeps a line-position counter, decodes that position into the blanking segments that follow the sync tip, drives an active-low sync output toward the host, and raises a one-cycle strobe at the point where the composite sync edge crosses half amplitude. The lengths of the sync tip, the breezeway, the colour burst and the colour back porch, and the total line length, are plain input ports.

The block runs in one of two modes. In free-run mode the counter wraps on its own at the programmed line length. In genlock mode each line is anchored to the falling edge of an external active-low sync input. The host sync output and the half-amplitude strobe follow that edge with fixed latencies. The front porch takes up any difference: a late edge stretches the porch, and an early edge cuts the line short.

Top module: `hline_timer`

## Requirements
- R1: While `rst` is high, and until the first line starts, `line_pos` is 0, `hsync_n` is 1, `seg` is 0 (idle) and `sync_mid` is 0. In free-run mode the first line starts at the first rising clock edge after `rst` falls.
- R2: In free-run mode (`genlock_en` = 0), `line_pos` rises by one per clock from 0 to `len_line`-1. It then returns to 0, which starts a new line.
- R3: Once a line has started, `hsync_n` is 0 exactly while `line_pos` < `len_sync`, and 1 otherwise.
- R4: `seg` encodes the segment of the current position. 1 is the sync tip, for the first `len_sync` positions. 2 is the breezeway, for the next `len_breeze` positions. 3 is the burst, for the next `len_burst`. 4 is the colour back porch, for the next `len_back`. 5 is the picture and front porch, for the rest of the line. 0 is idle, before the first line.
- R5: `sync_mid` is high for exactly one cycle in each line, at `line_pos` = 37 (the half-amplitude latency minus the host sync latency).
- R6: In free-run mode, edges on `ext_hsync_n` have no effect on `line_pos` or on any output.
- R7: In genlock mode, a falling edge on `ext_hsync_n` starts a new line. `line_pos` becomes 0 and `hsync_n` goes low at the 13th rising clock edge after the input falls. The input passes through a two-flop synchronizer before its edge is detected.
- R8: In genlock mode, `sync_mid` is high after the 50th rising clock edge following the fall of `ext_hsync_n`.
- R9: In genlock mode, if no edge arrives by the end of the line, `line_pos` holds at `len_line`-1 with `hsync_n` high. This stretches the front porch until the edge comes.
- R10: In genlock mode, an edge that arrives before the end of the line restarts the line from its fixed latency. The current line is cut short.
- R11: In genlock mode after reset, the outputs stay idle until the first external edge starts a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| genlock_en | input | 1 | 1 = lock to the external sync, 0 = free-run |
| ext_hsync_n | input | 1 | External active-low horizontal sync (asynchronous) |
| len_sync | input | SEG_W | Sync tip length in clocks |
| len_breeze | input | SEG_W | Breezeway length in clocks |
| len_burst | input | SEG_W | Burst length in clocks |
| len_back | input | SEG_W | Colour back porch length in clocks |
| len_line | input | POS_W | Total line length in clocks |
| hsync_n | output | 1 | Active-low host sync |
| sync_mid | output | 1 | One-cycle strobe at the half-amplitude point of the sync edge |
| seg | output | 3 | Current segment code (see R4) |
| line_pos | output | POS_W | Position within the line |

## Verification
The bench builds the block with its default parameters: 8-bit segment lengths, a 12-bit position counter, and latencies of 13 and 50. At run time it programs a short 60-clock line with segments of 4, 2, 5 and 3 clocks. The line is short enough that every position of two whole free-run lines, and of several locked lines, can be compared against values the bench works out arithmetically. That reaches the wrap, every segment boundary, a late edge held at the last position, and an early edge that cuts a line mid-picture.

// File: rtl/hline_pkg.sv
package hline_pkg;

    // Segment codes presented on the seg output
    typedef enum logic [2:0] {
        SEG_IDLE    = 3'd0,
        SEG_SYNC    = 3'd1,
        SEG_BREEZE  = 3'd2,
        SEG_BURST   = 3'd3,
        SEG_BACK    = 3'd4,
        SEG_PICTURE = 3'd5
    } seg_e;

    // Default output latencies counted from the external sync fall
    localparam int HS_LAT_DEF  = 13;
    localparam int MID_LAT_DEF = 50;

    // Register stages between the pin and the detected edge
    localparam int SYNC_STAGES = 3;

    // Position, inside the line, of the half-amplitude strobe
    function automatic int mid_offset(input int hs_lat, input int mid_lat);
        return mid_lat - hs_lat;
    endfunction

endpackage

// File: rtl/hline_edge_sync.sv
module hline_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= pin_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign fall = prev_q & ~sync_q;
endmodule

// File: rtl/hline_lock_delay.sv
module hline_lock_delay #(
    parameter int HS_LAT = hline_pkg::HS_LAT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic fall,
    output logic fire
);
    // The edge reaches this stage SYNC_STAGES edges late; arming costs one more edge
    localparam int LOAD  = HS_LAT - hline_pkg::SYNC_STAGES - 1;
    localparam int CNT_W = $clog2(HS_LAT);

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (fall) begin
            pend_q <= 1'b1;
            cnt_q  <= CNT_W'(LOAD);
        end else if (pend_q) begin
            if (cnt_q == '0) pend_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign fire = enable & pend_q & (cnt_q == '0) & ~fall;
endmodule

// File: rtl/hline_counter.sv
module hline_counter #(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             genlock_en,
    input  logic             fire,
    input  logic [POS_W-1:0] len_line,
    output logic [POS_W-1:0] pos,
    output logic             run
);
    logic [POS_W-1:0] last;
    assign last = len_line - POS_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            run <= 1'b0;
        end else if (genlock_en) begin
            if (fire) begin
                pos <= '0;
                run <= 1'b1;
            end else if (run && pos < last) begin
                pos <= pos + 1'b1;
            end
        end else begin
            run <= 1'b1;
            if (!run || pos >= last) pos <= '0;
            else                     pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/hline_seg_decode.sv
module hline_seg_decode
    import hline_pkg::*;
#(
    parameter int POS_W   = 12,
    parameter int SEG_W   = 8,
    parameter int HS_LAT  = HS_LAT_DEF,
    parameter int MID_LAT = MID_LAT_DEF
) (
    input  logic [POS_W-1:0] pos,
    input  logic             run,
    input  logic [SEG_W-1:0] len_sync,
    input  logic [SEG_W-1:0] len_breeze,
    input  logic [SEG_W-1:0] len_burst,
    input  logic [SEG_W-1:0] len_back,
    output logic             hsync_n,
    output logic             sync_mid,
    output seg_e             seg
);
    localparam int SUM_W   = POS_W + 2;
    localparam int MID_OFS = mid_offset(HS_LAT, MID_LAT);

    logic [SUM_W-1:0] end_sync, end_breeze, end_burst, end_back, pos_x;

    assign pos_x      = SUM_W'(pos);
    assign end_sync   = SUM_W'(len_sync);
    assign end_breeze = end_sync   + SUM_W'(len_breeze);
    assign end_burst  = end_breeze + SUM_W'(len_burst);
    assign end_back   = end_burst  + SUM_W'(len_back);

    always_comb begin
        if (!run)                    seg = SEG_IDLE;
        else if (pos_x < end_sync)   seg = SEG_SYNC;
        else if (pos_x < end_breeze) seg = SEG_BREEZE;
        else if (pos_x < end_burst)  seg = SEG_BURST;
        else if (pos_x < end_back)   seg = SEG_BACK;
        else                         seg = SEG_PICTURE;
    end

    assign hsync_n  = (seg != SEG_SYNC);
    assign sync_mid = run && (pos == POS_W'(MID_OFS));
endmodule

// File: rtl/hline_timer.sv
module hline_timer
    import hline_pkg::*;
#(
    parameter int POS_W   = 12,
    parameter int SEG_W   = 8,
    parameter int HS_LAT  = HS_LAT_DEF,
    parameter int MID_LAT = MID_LAT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             genlock_en,
    input  logic             ext_hsync_n,
    input  logic [SEG_W-1:0] len_sync,
    input  logic [SEG_W-1:0] len_breeze,
    input  logic [SEG_W-1:0] len_burst,
    input  logic [SEG_W-1:0] len_back,
    input  logic [POS_W-1:0] len_line,
    output logic             hsync_n,
    output logic             sync_mid,
    output logic [2:0]       seg,
    output logic [POS_W-1:0] line_pos
);
    logic ext_fall;
    logic lock_fire;
    logic line_run;
    seg_e seg_code;

    hline_edge_sync u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_n (ext_hsync_n),
        .fall  (ext_fall)
    );

    hline_lock_delay #(.HS_LAT(HS_LAT)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .enable (genlock_en),
        .fall   (ext_fall),
        .fire   (lock_fire)
    );

    hline_counter #(.POS_W(POS_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .genlock_en (genlock_en),
        .fire       (lock_fire),
        .len_line   (len_line),
        .pos        (line_pos),
        .run        (line_run)
    );

    hline_seg_decode #(
        .POS_W(POS_W), .SEG_W(SEG_W), .HS_LAT(HS_LAT), .MID_LAT(MID_LAT)
    ) u_decode (
        .pos        (line_pos),
        .run        (line_run),
        .len_sync   (len_sync),
        .len_breeze (len_breeze),
        .len_burst  (len_burst),
        .len_back   (len_back),
        .hsync_n    (hsync_n),
        .sync_mid   (sync_mid),
        .seg        (seg_code)
    );

    assign seg = seg_code;
endmodule

// File: rtl/hline_timer_chk.sv
module hline_timer_chk #(
    parameter int POS_W = 12,
    parameter int SEG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             genlock_en,
    input logic [SEG_W-1:0] len_sync,
    input logic [POS_W-1:0] len_line,
    input logic             hsync_n,
    input logic             sync_mid,
    input logic [2:0]       seg,
    input logic [POS_W-1:0] line_pos,
    input logic             lock_fire
);
    // R1: reset leaves every output idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (hsync_n && seg == 3'd0 && !sync_mid && line_pos == '0));

    // R2: free-run wraps after the last position
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!genlock_en && seg != 3'd0 && line_pos == len_line - POS_W'(1))
        |=> line_pos == '0);

    // R3: the host sync only falls at the start of a line
    p_hsync_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> line_pos == '0);

    // R4: segments only advance in order, except a restart into the sync tip
    p_seg_order_r4: assert property (@(posedge clk) disable iff (rst)
        (len_sync != '0 && seg != $past(seg) && seg != 3'd1) |-> seg > $past(seg));

    // R5: the half-amplitude strobe lasts one cycle
    p_mid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (sync_mid && line_pos != len_line - POS_W'(1)) |=> !sync_mid);

    // R7: a lock event starts a line with the host sync low
    p_fire_start_r7: assert property (@(posedge clk) disable iff (rst)
        (lock_fire && genlock_en) |=> (line_pos == '0 && (len_sync == '0 || !hsync_n)));

    // R9: with no lock event, a locked line holds at its last position
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (genlock_en && seg != 3'd0 && !lock_fire && line_pos == len_line - POS_W'(1))
        |=> line_pos == $past(line_pos));
endmodule

bind hline_timer hline_timer_chk #(.POS_W(POS_W), .SEG_W(SEG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .genlock_en (genlock_en),
    .len_sync   (len_sync),
    .len_line   (len_line),
    .hsync_n    (hsync_n),
    .sync_mid   (sync_mid),
    .seg        (seg),
    .line_pos   (line_pos),
    .lock_fire  (lock_fire)
);

// File: tb/hline_timer_tb.sv
module hline_timer_tb;
    localparam int POS_W = 12;
    localparam int SEG_W = 8;
    localparam int SY = 4, BU = 2, BR = 5, CBP = 3, LL = 60;
    localparam int HS = 13, MID = 50, MOFS = 37;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             genlock_en = 1'b0;
    logic             ext_hsync_n = 1'b1;
    logic [SEG_W-1:0] len_sync = SEG_W'(SY);
    logic [SEG_W-1:0] len_breeze = SEG_W'(BU);
    logic [SEG_W-1:0] len_burst = SEG_W'(BR);
    logic [SEG_W-1:0] len_back = SEG_W'(CBP);
    logic [POS_W-1:0] len_line = POS_W'(LL);
    logic             hsync_n, sync_mid;
    logic [2:0]       seg;
    logic [POS_W-1:0] line_pos;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hline_timer u_dut (
        .clk(clk), .rst(rst), .genlock_en(genlock_en), .ext_hsync_n(ext_hsync_n),
        .len_sync(len_sync), .len_breeze(len_breeze), .len_burst(len_burst),
        .len_back(len_back), .len_line(len_line),
        .hsync_n(hsync_n), .sync_mid(sync_mid), .seg(seg), .line_pos(line_pos)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_seg(input bit run, input int p);
        if (!run)                   return 0;
        if (p < SY)                 return 1;
        if (p < SY + BU)            return 2;
        if (p < SY + BU + BR)       return 3;
        if (p < SY + BU + BR + CBP) return 4;
        return 5;
    endfunction

    task automatic check_all(input string tpos, input string tmid, input bit run, input int p);
        chk(tpos, "line_pos", int'(line_pos), p);
        chk("R3", "hsync_n", int'(hsync_n), (run && p < SY) ? 0 : 1);
        chk("R4", "seg", int'(seg), exp_seg(run, p));
        chk(tmid, "sync_mid", int'(sync_mid), (run && p == MOFS) ? 1 : 0);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input bit lock);
        rst = 1'b1;
        genlock_en = lock;
        ext_hsync_n = 1'b1;
        repeat (3) step();
        check_all("R1", "R1", 1'b0, 0);
        rst = 1'b0;
    endtask

    // mode 0: idle before the edge; 1: holding at pre; 2: advancing from pre
    task automatic run_lock(input int mode, input int pre, input int n);
        ext_hsync_n = 1'b0;
        for (int j = 1; j <= n; j++) begin
            step();
            if (j == 25) ext_hsync_n = 1'b1;
            if (j < HS) begin
                if (mode == 0)      check_all("R11", "R11", 1'b0, 0);
                else if (mode == 1) check_all("R9", "R5", 1'b1, pre);
                else                check_all("R10", "R5", 1'b1, pre + j);
            end else begin
                int p = j - HS;
                string tp;
                if (p > LL - 1) p = LL - 1;
                tp = (j == HS) ? ((mode == 2) ? "R10" : "R7") : ((j - HS > LL - 1) ? "R9" : "R2");
                check_all(tp, (j == MID) ? "R8" : "R5", 1'b1, p);
            end
        end
    endtask

    initial begin
        // Free-run mode
        do_reset(1'b0);
        for (int i = 0; i < 3 * LL; i++) begin
            step();
            if (i == LL + 5)  ext_hsync_n = 1'b0;
            if (i == LL + 30) ext_hsync_n = 1'b1;
            if (i == 2 * LL + 7) ext_hsync_n = 1'b0;
            check_all((i < LL) ? "R2" : "R6", (i < LL) ? "R5" : "R6", 1'b1, i % LL);
        end

        // Genlock mode: idle until the first edge
        do_reset(1'b1);
        for (int i = 0; i < 2 * LL; i++) begin
            step();
            check_all("R11", "R11", 1'b0, 0);
        end
        run_lock(0, 0, 100);   // first edge, then the line holds at its end
        run_lock(1, LL - 1, 53); // late edge; leaves the line at position 40
        run_lock(2, 40, 100);  // early edge cuts the line short

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule